// File: doc/BRIEF.md
# DDR4 Bank Command Sequencer

This block turns a stream of read and write requests into a legal series of DDR4 bank commands. Each request names a bank group, a bank, a row and a starting column. The sequencer keeps the open or closed state and the open row of every bank. It then emits the commands that the request needs, one per clock:
- a request to an open bank and its open row gets the column command alone;
- a request to a different row in an open bank gets a precharge, an activate and then the column command;
- a request to a closed bank gets an activate and then the column command.

The row-to-column delay, the precharge time and the read latency are plain control inputs that give counts in clocks. Column commands carry the auto-precharge request on address bit 10 and the burst size on address bit 12. A separate output is high in each clock in which read data is due on the data pins.

Requests arrive on a valid/ready port. A request is taken in a cycle where `req_valid` and `req_ready` are both high. The requester must hold `req_valid` and all request fields stable until that cycle. `req_ready` is low while an earlier request is still waiting for its commands. It rises again in the cycle in which that request's column command is decided, so a held request is taken in that same cycle. With parameter `X16` set, the block has 8 banks in 2 groups and uses only bank-group bit 0. The default has 16 banks in 4 groups.

Top module: `bank_cmd_seq`

## Requirements
- R1: After reset, `cmd_valid`, `rd_data_expected` and `illegal_seq` are low and `req_ready` is high.
- R2: A request to a closed bank issues ACTIVATE first. ACTIVATE carries the bank group and bank on `cmd_bg`/`cmd_ba` and the row on `cmd_addr`. The column command follows it, with the column on `cmd_addr[9:0]` and `cmd_addr[11]` low. `cmd_type` encodes ACTIVATE=0, READ=1, WRITE=2, PRECHARGE=3.
- R3: A column command to a bank is issued exactly `cfg_trcd` clocks after that bank's ACTIVATE when nothing else holds it back. It is never issued earlier than that.
- R4: A request to an open bank with a different row issues PRECHARGE with `cmd_addr` all zero. ACTIVATE follows `cfg_trp` clocks later, then the column command.
- R5: A request to the open row of an open bank issues its column command two clocks after the cycle in which the request is taken, with no ACTIVATE or PRECHARGE.
- R6: `cmd_addr[10]` of a column command equals the request's auto-precharge bit. After such a command the bank counts as closed. Its next ACTIVATE comes no earlier than the burst clocks plus `cfg_trp` after the column command.
- R7: `cmd_addr[12]` is 1 for an eight-beat burst (4 clocks) and 0 for a chopped four-beat burst (2 clocks). With `cfg_otf_en` high, `req_chop`=1 selects the chopped burst. With `cfg_otf_en` low, `cfg_bl8` selects the size and `req_chop` has no effect.
- R8: `rd_data_expected` is high for exactly the burst clocks, starting `cfg_cl` clocks after a READ. Overlapping windows merge. A WRITE never raises it.
- R9: `req_ready` is low while a taken request waits for a PRECHARGE or an ACTIVATE. It is high in the cycle that decides the pending column command, so back-to-back row hits issue column commands on consecutive clocks. At most one command is issued per clock.
- R10: `illegal_seq` goes high and stays high if a column command ever targets a closed bank. In correct operation it stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_trcd | input | CNT_W | Activate-to-column delay in clocks (1 or more) |
| cfg_trp | input | CNT_W | Precharge-to-activate delay in clocks (1 or more) |
| cfg_cl | input | CNT_W | Read latency in clocks (1 to MAX_CL) |
| cfg_otf_en | input | 1 | Burst size taken from each request |
| cfg_bl8 | input | 1 | Fixed burst size when per-request selection is off (1 = eight beats) |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bg | input | 2 | Bank group |
| req_ba | input | 2 | Bank within group |
| req_row | input | ROW_W | Row address |
| req_col | input | COL_W | Starting column |
| req_autopre | input | 1 | Close the bank after the burst |
| req_chop | input | 1 | Chopped burst request |
| cmd_valid | output | 1 | Command present this clock |
| cmd_type | output | 2 | Command code |
| cmd_bg | output | 2 | Command bank group |
| cmd_ba | output | 2 | Command bank |
| cmd_addr | output | ROW_W | Command address bus |
| rd_data_expected | output | 1 | Read data due on the data pins this clock |
| illegal_seq | output | 1 | Sticky flag: column command to a closed bank |

## Verification
Two functions can fall in the same cycle: taking a new request, and deciding the column command of the request already held. In that cycle `req_ready` rises while the earlier request is still pending. The bench provokes this by holding two row-hit reads back to back on the request port. It checks that the second one is taken in the very cycle the first column command is decided, and that the two column commands come out on consecutive clocks. The two read windows then overlap. The bench checks that `rd_data_expected` stays high for one merged run of five clocks, starting the read latency after the first READ.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

  typedef enum logic [1:0] {
    CMD_ACT = 2'b00,
    CMD_RD  = 2'b01,
    CMD_WR  = 2'b10,
    CMD_PRE = 2'b11
  } cmd_e;

  // Clocks a burst occupies on the data pins
  function automatic logic [2:0] burst_clks(input logic chopped);
    return chopped ? 3'd2 : 3'd4;
  endfunction

endpackage

// File: rtl/bcs_bank_track.sv
module bcs_bank_track
  import bcs_pkg::*;
#(
  parameter int NBANK = 16,
  parameter int ROW_W = 18,
  parameter int CNT_W = 6,
  parameter int BK_W  = $clog2(NBANK)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             iss_valid,
  input  cmd_e             iss_type,
  input  logic [BK_W-1:0]  iss_bank,
  input  logic [ROW_W-1:0] iss_row,
  input  logic             iss_ap,
  input  logic [2:0]       iss_burst,
  input  logic [CNT_W-1:0] cfg_trcd,
  input  logic [CNT_W-1:0] cfg_trp,
  input  logic [BK_W-1:0]  q_bank,
  input  logic [ROW_W-1:0] q_row,
  output logic             q_open,
  output logic             q_hit,
  output logic             q_act_ok,
  output logic             q_col_ok,
  output logic             col_err
);
  localparam int TW = CNT_W + 1;

  logic [NBANK-1:0] open_q;
  logic [ROW_W-1:0] row_q   [NBANK];
  logic [TW-1:0]    act_cnt [NBANK];
  logic [TW-1:0]    col_cnt [NBANK];

  logic          is_col;
  logic [TW-1:0] trcd_ld, trp_ld, ap_ld;

  assign is_col  = (iss_type == CMD_RD) || (iss_type == CMD_WR);
  assign trcd_ld = (cfg_trcd == '0) ? '0 : TW'(cfg_trcd) - TW'(1);
  assign trp_ld  = (cfg_trp == '0) ? '0 : TW'(cfg_trp) - TW'(1);
  assign ap_ld   = TW'(cfg_trp) + TW'(iss_burst) - TW'(1);

  for (genvar i = 0; i < NBANK; i++) begin : g_bank
    logic sel;
    assign sel = iss_valid && (iss_bank == BK_W'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        open_q[i]  <= 1'b0;
        row_q[i]   <= '0;
        act_cnt[i] <= '0;
        col_cnt[i] <= '0;
      end else begin
        if (sel && iss_type == CMD_ACT) begin
          open_q[i] <= 1'b1;
          row_q[i]  <= iss_row;
        end else if (sel && (iss_type == CMD_PRE || (is_col && iss_ap))) begin
          open_q[i] <= 1'b0;
        end

        if (sel && iss_type == CMD_PRE)       act_cnt[i] <= trp_ld;
        else if (sel && is_col && iss_ap)     act_cnt[i] <= ap_ld;
        else if (act_cnt[i] != '0)            act_cnt[i] <= act_cnt[i] - TW'(1);

        if (sel && iss_type == CMD_ACT)       col_cnt[i] <= trcd_ld;
        else if (col_cnt[i] != '0)            col_cnt[i] <= col_cnt[i] - TW'(1);
      end
    end

    // R6: an auto-precharge column command leaves the bank closed
    a_r6_ap_closes: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && is_col && iss_ap) |=> !open_q[i]);
  end

  assign q_open   = open_q[q_bank];
  assign q_hit    = (row_q[q_bank] == q_row);
  assign q_act_ok = (act_cnt[q_bank] == '0);
  assign q_col_ok = (col_cnt[q_bank] == '0);
  assign col_err  = iss_valid && is_col && !open_q[iss_bank];

  // R3: column command only once the activate delay has run out
  a_r3_trcd_met: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && is_col) |-> (col_cnt[iss_bank] == '0));

  // R4: activate only to a closed bank whose precharge time has run out
  a_r4_trp_met: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_type == CMD_ACT) |-> (act_cnt[iss_bank] == '0 && !open_q[iss_bank]));

  // R2: column command only to an open bank
  a_r2_col_open: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && is_col) |-> open_q[iss_bank]);

endmodule

// File: rtl/bcs_rd_window.sv
module bcs_rd_window #(
  parameter int CNT_W  = 6,
  parameter int MAX_CL = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] cl,
  input  logic [2:0]       burst,
  output logic             rd_exp
);
  localparam int DEPTH = MAX_CL + 5;

  logic [DEPTH-1:0] sr_q, mask;

  always_comb begin
    for (int i = 0; i < DEPTH; i++)
      mask[i] = (i >= int'(cl)) && (i < int'(cl) + int'(burst));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= {1'b0, sr_q[DEPTH-1:1]} | (load ? mask : '0);
  end

  assign rd_exp = sr_q[0];

  // R8: with no read in flight and none arriving, the window stays shut
  a_r8_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_q == '0 && !load) |=> !rd_exp);

endmodule

// File: rtl/bank_cmd_seq.sv
module bank_cmd_seq
  import bcs_pkg::*;
#(
  parameter int X16    = 0,
  parameter int ROW_W  = 18,
  parameter int COL_W  = 10,
  parameter int CNT_W  = 6,
  parameter int MAX_CL = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cfg_trcd,
  input  logic [CNT_W-1:0] cfg_trp,
  input  logic [CNT_W-1:0] cfg_cl,
  input  logic             cfg_otf_en,
  input  logic             cfg_bl8,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [1:0]       req_bg,
  input  logic [1:0]       req_ba,
  input  logic [ROW_W-1:0] req_row,
  input  logic [COL_W-1:0] req_col,
  input  logic             req_autopre,
  input  logic             req_chop,
  output logic             cmd_valid,
  output logic [1:0]       cmd_type,
  output logic [1:0]       cmd_bg,
  output logic [1:0]       cmd_ba,
  output logic [ROW_W-1:0] cmd_addr,
  output logic             rd_data_expected,
  output logic             illegal_seq
);
  localparam int NBG   = (X16 != 0) ? 2 : 4;
  localparam int NBANK = NBG * 4;
  localparam int BK_W  = $clog2(NBANK);

  // Bank index and normalised bank group of the incoming request
  logic [BK_W-1:0] req_bank;
  logic [1:0]      req_bg_n;
  if (X16 != 0) begin : g_x16
    assign req_bank = {req_bg[0], req_ba};
    assign req_bg_n = {1'b0, req_bg[0]};
  end else begin : g_x8
    assign req_bank = {req_bg, req_ba};
    assign req_bg_n = req_bg;
  end

  // Pending request
  logic             pend_v, p_write, p_ap, p_chop;
  logic [BK_W-1:0]  p_bank;
  logic [1:0]       p_bg, p_ba;
  logic [ROW_W-1:0] p_row;
  logic [COL_W-1:0] p_col;

  // Bank state queried for the pending request
  logic q_open, q_hit, q_act_ok, q_col_ok, col_err;

  // Decision
  logic       act_fire, pre_fire, col_fire, iss_valid, chop_eff, accept;
  cmd_e       iss_type;
  logic [2:0] burst;
  logic [ROW_W-1:0] col_addr, iss_addr;

  assign chop_eff = cfg_otf_en ? p_chop : !cfg_bl8;
  assign burst    = burst_clks(chop_eff);

  assign col_fire  = pend_v && q_open && q_hit && q_col_ok;
  assign pre_fire  = pend_v && q_open && !q_hit;
  assign act_fire  = pend_v && !q_open && q_act_ok;
  assign iss_valid = col_fire || pre_fire || act_fire;

  always_comb begin
    if (act_fire)      iss_type = CMD_ACT;
    else if (pre_fire) iss_type = CMD_PRE;
    else if (p_write)  iss_type = CMD_WR;
    else               iss_type = CMD_RD;
  end

  always_comb begin
    col_addr              = '0;
    col_addr[COL_W-1:0]   = p_col;
    col_addr[10]          = p_ap;
    col_addr[12]          = !chop_eff;
  end

  always_comb begin
    if (act_fire)      iss_addr = p_row;
    else if (pre_fire) iss_addr = '0;
    else               iss_addr = col_addr;
  end

  assign req_ready = !pend_v || col_fire;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_v  <= 1'b0;
      p_write <= 1'b0;
      p_ap    <= 1'b0;
      p_chop  <= 1'b0;
      p_bank  <= '0;
      p_bg    <= '0;
      p_ba    <= '0;
      p_row   <= '0;
      p_col   <= '0;
    end else if (accept) begin
      pend_v  <= 1'b1;
      p_write <= req_write;
      p_ap    <= req_autopre;
      p_chop  <= req_chop;
      p_bank  <= req_bank;
      p_bg    <= req_bg_n;
      p_ba    <= req_ba;
      p_row   <= req_row;
      p_col   <= req_col;
    end else if (col_fire) begin
      pend_v  <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_valid   <= 1'b0;
      cmd_type    <= 2'b00;
      cmd_bg      <= '0;
      cmd_ba      <= '0;
      cmd_addr    <= '0;
      illegal_seq <= 1'b0;
    end else begin
      cmd_valid <= iss_valid;
      cmd_type  <= iss_valid ? iss_type : 2'b00;
      cmd_bg    <= iss_valid ? p_bg : 2'b00;
      cmd_ba    <= iss_valid ? p_ba : 2'b00;
      cmd_addr  <= iss_valid ? iss_addr : '0;
      if (col_err) illegal_seq <= 1'b1;
    end
  end

  bcs_bank_track #(
    .NBANK (NBANK),
    .ROW_W (ROW_W),
    .CNT_W (CNT_W),
    .BK_W  (BK_W)
  ) u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .iss_valid (iss_valid),
    .iss_type  (iss_type),
    .iss_bank  (p_bank),
    .iss_row   (p_row),
    .iss_ap    (p_ap),
    .iss_burst (burst),
    .cfg_trcd  (cfg_trcd),
    .cfg_trp   (cfg_trp),
    .q_bank    (p_bank),
    .q_row     (p_row),
    .q_open    (q_open),
    .q_hit     (q_hit),
    .q_act_ok  (q_act_ok),
    .q_col_ok  (q_col_ok),
    .col_err   (col_err)
  );

  bcs_rd_window #(
    .CNT_W  (CNT_W),
    .MAX_CL (MAX_CL)
  ) u_rdwin (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (col_fire && !p_write),
    .cl     (cfg_cl),
    .burst  (burst),
    .rd_exp (rd_data_expected)
  );

  // R9: a waiting request is held unchanged until its column command
  a_r9_pend_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_v && !col_fire) |=> (pend_v && $stable(p_bank) && $stable(p_row) && $stable(p_col)));

  // R9: an issued precharge or activate is followed by no column command in the same decision
  a_r9_single_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({act_fire, pre_fire, col_fire}));

  // R10: the sequence flag never rises
  a_r10_no_illegal: assert property (@(posedge clk) disable iff (!rst_n)
    !illegal_seq);

endmodule

// File: tb/tb_bank_cmd_seq.sv
module tb_bank_cmd_seq;
  import bcs_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int ROW_W = 18;
  localparam int COL_W = 10;
  localparam int CNT_W = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [CNT_W-1:0] cfg_trcd = 6'd3, cfg_trp = 6'd3, cfg_cl = 6'd4;
  logic cfg_otf_en = 1'b1, cfg_bl8 = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0, req_autopre = 1'b0, req_chop = 1'b0;
  logic [1:0] req_bg = '0, req_ba = '0;
  logic [ROW_W-1:0] req_row = '0;
  logic [COL_W-1:0] req_col = '0;
  logic req_ready, cmd_valid, rd_data_expected, illegal_seq;
  logic [1:0] cmd_type, cmd_bg, cmd_ba;
  logic [ROW_W-1:0] cmd_addr;

  bank_cmd_seq dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_trcd(cfg_trcd), .cfg_trp(cfg_trp), .cfg_cl(cfg_cl),
    .cfg_otf_en(cfg_otf_en), .cfg_bl8(cfg_bl8),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_bg(req_bg), .req_ba(req_ba), .req_row(req_row), .req_col(req_col),
    .req_autopre(req_autopre), .req_chop(req_chop),
    .cmd_valid(cmd_valid), .cmd_type(cmd_type), .cmd_bg(cmd_bg), .cmd_ba(cmd_ba),
    .cmd_addr(cmd_addr), .rd_data_expected(rd_data_expected), .illegal_seq(illegal_seq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_tests = 0, n_fail = 0;

  // Reference bank model
  bit m_open [16];
  int m_row  [16];
  int m_act_ok [16];
  int m_col_ok [16];

  // {wr, bg, ba, row, col, ap, chop}
  localparam logic [34:0] VEC [10] = '{
    {1'b0, 2'd0, 2'd0, 18'd5,      10'd8,   1'b0, 1'b0},
    {1'b0, 2'd0, 2'd0, 18'd5,      10'd16,  1'b0, 1'b0},
    {1'b1, 2'd0, 2'd0, 18'd7,      10'd3,   1'b0, 1'b0},
    {1'b1, 2'd3, 2'd2, 18'h3FFFF,  10'h3FF, 1'b0, 1'b0},
    {1'b0, 2'd3, 2'd2, 18'h3FFFF,  10'd1,   1'b0, 1'b1},
    {1'b1, 2'd1, 2'd1, 18'd100,    10'd4,   1'b1, 1'b0},
    {1'b0, 2'd1, 2'd1, 18'd100,    10'd5,   1'b0, 1'b0},
    {1'b0, 2'd2, 2'd3, 18'd9,      10'd0,   1'b1, 1'b1},
    {1'b0, 2'd2, 2'd3, 18'd9,      10'd2,   1'b0, 1'b0},
    {1'b1, 2'd0, 2'd0, 18'd7,      10'd9,   1'b0, 1'b0}
  };

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  // Called at a falling edge; returns at the falling edge after the command
  task automatic wait_cmd(input cmd_e et, input int bg, input int ba, input int eaddr,
                          input int ecyc, input string req, output int got);
    int guard = 0;
    while (!cmd_valid && guard < 300) begin
      @(negedge clk);
      guard++;
    end
    got = cyc;
    if (!cmd_valid) begin
      check(1'b0, req, "command missing", 0, 1);
      return;
    end
    check(cyc == ecyc, req, "issue cycle", cyc, ecyc);
    check(cmd_type == et, req, "command type", int'(cmd_type), int'(et));
    check({cmd_bg, cmd_ba} == {bg[1:0], ba[1:0]}, req, "bank",
          int'({cmd_bg, cmd_ba}), int'({bg[1:0], ba[1:0]}));
    check(int'(cmd_addr) == eaddr, req, "address", int'(cmd_addr), eaddr);
    check(!illegal_seq, "R10", "illegal flag", int'(illegal_seq), 0);
    @(negedge clk);
  endtask

  // Watch rd_data_expected after a column command issued in cycle t
  task automatic watch_rd(input int t, input int exp_first, input int exp_cnt, input string req);
    int first = -1, cnt = 0;
    for (int k = 0; k < int'(cfg_cl) + 8; k++) begin
      if (rd_data_expected) begin
        cnt++;
        if (first < 0) first = cyc - t;
      end
      @(negedge clk);
    end
    check(first == exp_first, req, "read window start", first, exp_first);
    check(cnt == exp_cnt, req, "read window length", cnt, exp_cnt);
  endtask

  task automatic do_req(input bit wr, input int bg, input int ba, input int row,
                        input int col, input bit ap, input bit chop);
    int bk, c, t, e, b, eaddr;
    bit a12;
    bk = bg * 4 + ba;
    req_write = wr; req_bg = bg[1:0]; req_ba = ba[1:0];
    req_row = row[ROW_W-1:0]; req_col = col[COL_W-1:0];
    req_autopre = ap; req_chop = chop; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    c = cyc;
    @(negedge clk);
    req_valid = 1'b0;
    b   = cfg_otf_en ? (chop ? 2 : 4) : (cfg_bl8 ? 4 : 2);
    a12 = (b == 4);
    if (m_open[bk] && m_row[bk] == row) begin
      e = imax(c + 2, m_col_ok[bk]);                       // R5 row hit
    end else begin
      check(req_ready == 1'b0, "R9", "ready while pending", int'(req_ready), 0);
      if (m_open[bk]) begin
        wait_cmd(CMD_PRE, bg, ba, 0, c + 2, "R4", t);       // R4 row miss
        m_open[bk] = 1'b0;
        e = imax(t + int'(cfg_trp), m_act_ok[bk]);
      end else begin
        e = imax(c + 2, m_act_ok[bk]);                     // R6 waits after auto-precharge
      end
      wait_cmd(CMD_ACT, bg, ba, row, e, "R2", t);
      m_open[bk] = 1'b1; m_row[bk] = row;
      m_col_ok[bk] = t + int'(cfg_trcd);
      e = m_col_ok[bk];                                     // R3 activate-to-column
    end
    eaddr = col | (int'(ap) << 10) | (int'(a12) << 12);     // R6 A10, R7 A12
    wait_cmd(wr ? CMD_WR : CMD_RD, bg, ba, eaddr, e, "R3", t);
    if (ap) begin
      m_open[bk] = 1'b0;
      m_act_ok[bk] = t + b + int'(cfg_trp);
    end
    if (!wr)      watch_rd(t, int'(cfg_cl), b, "R8");
    else if (!ap) watch_rd(t, -1, 0, "R8");
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    check(1'b0, "watchdog", "run timed out", 0, 1);
    summary();
    $finish;
  end

  initial begin
    int c, t1, t2, first, cnt;
    for (int i = 0; i < 16; i++) begin
      m_open[i] = 1'b0; m_row[i] = 0; m_act_ok[i] = 0; m_col_ok[i] = 0;
    end
    repeat (3) @(negedge clk);
    // R1 reset state
    check(cmd_valid == 1'b0, "R1", "cmd_valid in reset", int'(cmd_valid), 0);
    check(req_ready == 1'b1, "R1", "req_ready in reset", int'(req_ready), 1);
    check(rd_data_expected == 1'b0, "R1", "read flag in reset", int'(rd_data_expected), 0);
    check(illegal_seq == 1'b0, "R1", "illegal flag in reset", int'(illegal_seq), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Table walk
    for (int i = 0; i < 10; i++) begin
      do_req(VEC[i][34], int'(VEC[i][33:32]), int'(VEC[i][31:30]), int'(VEC[i][29:12]),
             int'(VEC[i][11:2]), VEC[i][1], VEC[i][0]);
    end

    // New timing values
    cfg_cl = 6'd5; cfg_trcd = 6'd4; cfg_trp = 6'd5;
    do_req(1'b0, 2, 0, 77, 1, 1'b0, 1'b0);
    do_req(1'b1, 2, 0, 78, 6, 1'b0, 1'b0);

    // R7: fixed burst size, req_chop ignored
    cfg_otf_en = 1'b0; cfg_bl8 = 1'b0;
    do_req(1'b0, 2, 0, 78, 2, 1'b0, 1'b0);
    cfg_bl8 = 1'b1;
    do_req(1'b0, 2, 0, 78, 3, 1'b0, 1'b1);
    cfg_otf_en = 1'b1;

    // R9: back-to-back row hits; second taken while first column command is decided
    req_write = 1'b0; req_bg = 2'd2; req_ba = 2'd0; req_row = 18'd78;
    req_col = 10'd20; req_autopre = 1'b0; req_chop = 1'b0; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    c = cyc;
    @(negedge clk);
    req_col = 10'd24;
    check(req_ready == 1'b1, "R9", "ready in column-decide cycle", int'(req_ready), 1);
    @(negedge clk);
    req_valid = 1'b0;
    check(cmd_valid && cmd_type == 2'(CMD_RD) && cmd_addr == 18'h01014, "R9",
          "first column command", int'(cmd_addr), 32'h01014);
    t1 = cyc;
    @(negedge clk);
    check(cmd_valid && cmd_type == 2'(CMD_RD) && cmd_addr == 18'h01018, "R9",
          "second column on next clock", int'(cmd_addr), 32'h01018);
    t2 = cyc;
    check(t2 == t1 + 1 && t1 == c + 2, "R9", "consecutive issue cycle", t2 - t1, 1);
    first = -1; cnt = 0;
    for (int k = 0; k < int'(cfg_cl) + 10; k++) begin
      if (rd_data_expected) begin
        cnt++;
        if (first < 0) first = cyc - t1;
      end
      @(negedge clk);
    end
    check(first == int'(cfg_cl), "R8", "merged window start", first, int'(cfg_cl));
    check(cnt == 5, "R8", "merged window length", cnt, 5);

    check(illegal_seq == 1'b0, "R10", "illegal flag at end", int'(illegal_seq), 0);
    summary();
    $finish;
  end

endmodule